// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Master

This block is a polled synchronous serial master that moves one byte at a time over a single shared data line. It drives a serial clock, two active-low slave-enable outputs and the output half of the data line. It reads the input half of the data line when it receives. Software controls it through four byte-wide registers, all on a small write/read bus. Software writes a byte to start a transmit, or sets a start bit in the control register to start a receive. It then polls a busy flag until the transfer is over. No interrupt is raised.

The serial clock runs at one of four fractions of the system clock: one half, one quarter, one eighth or one sixteenth. At the fastest setting each system clock pair carries one bit, so a 50 MHz system clock gives 25 Mbit/s. The clock rests low between transfers. The data line is driven only while a transmit is in progress. During a receive, and when idle, the line is released so that a slave can drive it.

The enables are plain control bits, so software can keep one slave selected across several bytes in both directions. Register map (address on `bus_addr`):
- Address 0 is the control register: divider code in bits 1:0, enable request for slave 0 in bit 2, for slave 1 in bit 3, and receive start in bit 4.
- Address 1 is status: busy in bit 0.
- Address 2 is transmit data.
- Address 3 is receive data.

Top module: `hdsm_top`

## Requirements
- R1: After reset, `sclk_o`=0, `sdata_oe`=0, `sdata_o`=0 and `sel_n`=2'b11, and every register reads 0.
- R2: The divider code in control bits 1:0 (0, 1, 2, 3) sets the serial clock period to 2, 4, 8 or 16 system clocks. The first rising edge comes half a period after the start, and the clock is high for half of every period. A transfer has exactly 8 rising edges.
- R3: A bus write to address 2 while idle starts a transmit. `sdata_oe` is 1 during the whole transfer. The byte appears on `sdata_o` most significant bit first. Each bit is stable around its rising serial clock edge, and bits change only after a falling edge.
- R4: A control write with bit 4 set while idle starts a receive. `sdata_oe` stays 0 throughout. `sdata_i` is sampled at each rising serial clock edge, most significant bit first. The assembled byte is readable at address 3 once the transfer ends.
- R5: Status bit 0 (busy) is 1 for exactly 8 serial clock periods, that is 8 x 2^(code+1) system clocks. It sets with the accepting write and clears with the eighth falling edge.
- R6: Whenever busy is 0, `sclk_o` is 0 and `sdata_oe` is 0.
- R7: `sel_n[k]` equals the inverse of control bit 2+k. It updates one cycle after any control write, whether busy or not, and holds across transfers until the next control write.
- R8: While busy, writes to address 2, the receive start bit and the divider field are ignored. A write that lands on the cycle of the final falling edge is ignored too.
- R9: A read returns its register on `bus_rdata` one cycle after `bus_addr` is presented:
  - address 0 gives {3'b0, 1'b0, enable bits, divider code};
  - address 1 gives {7'b0, busy};
  - address 2 gives the last accepted transmit byte;
  - address 3 gives the last received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for write and read |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| sclk_o | output | 1 | Serial clock, idles low |
| sdata_o | output | 1 | Serial data out (valid when `sdata_oe` is 1) |
| sdata_oe | output | 1 | Drive enable for the shared data line |
| sdata_i | input | 1 | Serial data in from the shared data line |
| sel_n | output | 2 | Active-low slave enables |

## Verification
Two things can land in the same cycle: a software register write and the clock strobes of the serial engine. The sharpest such case is a transmit write that arrives on the very edge where the eighth falling clock edge ends the transfer. The bench places a write on that exact cycle at the fastest divider. It then judges that no second transfer started, that the transmit register still holds the old byte, and that the line stayed quiet. In a separate slow transfer, data, start-bit and control writes are issued between serial edges. The bench checks that the shifted byte, the divider and the transfer length are unchanged, while the enables do follow the write.

// File: rtl/hdsm_pkg.sv
package hdsm_pkg;

  // Register selector on the host bus
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TXD  = 2'd2,
    REG_RXD  = 2'd3
  } reg_sel_e;

  // Bit used for the busy flag in the status register
  localparam int STAT_BUSY_BIT = 0;

endpackage

// File: rtl/hdsm_clkgen.sv
module hdsm_clkgen #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_code,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb
);

  // Half period is 2^code system clocks; largest code sets the width
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] hcnt;
  logic [CNT_W-1:0] half_m1;
  logic             phase_end;

  assign half_m1   = CNT_W'((32'd1 << div_code) - 32'd1);
  assign phase_end = run && (hcnt == half_m1);
  assign rise_stb  = phase_end && !sclk;
  assign fall_stb  = phase_end && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hcnt <= '0;
      sclk <= 1'b0;
    end else if (phase_end) begin
      hcnt <= '0;
      sclk <= ~sclk;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  AST_RISE_GOES_HIGH: assert property (@(posedge clk) disable iff (rst)
    rise_stb |=> sclk);  // R2
  AST_FALL_GOES_LOW: assert property (@(posedge clk) disable iff (rst)
    fall_stb |=> !sclk);  // R2
  AST_NO_STRAY_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (run && !rise_stb && !fall_stb) |=> $stable(sclk));  // R2

endmodule

// File: rtl/hdsm_engine.sv
module hdsm_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_tx,
  input  logic              start_rx,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              sdata_i,
  output logic              busy,
  output logic              sdata_o,
  output logic              sdata_oe,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [BIT_W-1:0]  bitcnt;
  logic              last_fall;

  assign last_fall = busy && fall_stb && (bitcnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sdata_oe <= 1'b0;
      sdata_o  <= 1'b0;
      shreg    <= '0;
      bitcnt   <= '0;
      rx_byte  <= '0;
    end else if (!busy) begin
      if (start_tx) begin
        busy     <= 1'b1;
        sdata_oe <= 1'b1;
        shreg    <= load_byte;
        sdata_o  <= load_byte[DATA_W-1];
        bitcnt   <= '0;
      end else if (start_rx) begin
        busy     <= 1'b1;
        sdata_oe <= 1'b0;
        shreg    <= '0;
        sdata_o  <= 1'b0;
        bitcnt   <= '0;
      end
    end else begin
      if (rise_stb && !sdata_oe) begin
        shreg <= {shreg[DATA_W-2:0], sdata_i};
      end
      if (last_fall) begin
        busy     <= 1'b0;
        sdata_oe <= 1'b0;
        sdata_o  <= 1'b0;
        if (!sdata_oe) rx_byte <= shreg;
      end else if (fall_stb) begin
        bitcnt <= bitcnt + 1'b1;
        if (sdata_oe) begin
          shreg   <= {shreg[DATA_W-2:0], 1'b0};
          sdata_o <= shreg[DATA_W-2];
        end
      end
    end
  end

  AST_OE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (rst)
    sdata_oe |-> busy);  // R6
  AST_TX_START_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_tx) |=> (busy && sdata_oe));  // R3
  AST_RX_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_rx && !start_tx) |=> (busy && !sdata_oe));  // R4
  AST_SHIFT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (busy && !rise_stb && !fall_stb) |=> $stable(shreg));  // R8
  AST_RX_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_fall) |=> $stable(rx_byte));  // R4

endmodule

// File: rtl/hdsm_regs.sv
module hdsm_regs
  import hdsm_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 2,
  parameter int NUM_SEL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DIV_W-1:0]  div_code,
  output logic [NUM_SEL-1:0] sel_n,
  output logic              start_tx,
  output logic              start_rx
);

  localparam int EN_LSB   = DIV_W;
  localparam int RXGO_BIT = DIV_W + NUM_SEL;

  reg_sel_e          sel;
  logic              wr_ctrl;
  logic              wr_txd;
  logic [DATA_W-1:0] tx_hold;
  logic [DATA_W-1:0] rd_mux;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_ctrl = bus_wr && (sel == REG_CTRL);
  assign wr_txd  = bus_wr && (sel == REG_TXD);

  always_comb begin
    start_tx = wr_txd && !busy;
    start_rx = wr_ctrl && !busy && bus_wdata[RXGO_BIT];
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_CTRL: begin
        rd_mux[DIV_W-1:0]          = div_code;
        rd_mux[EN_LSB +: NUM_SEL]  = ~sel_n;
      end
      REG_STAT: rd_mux[STAT_BUSY_BIT] = busy;
      REG_TXD:  rd_mux = tx_hold;
      REG_RXD:  rd_mux = rx_byte;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_code  <= '0;
      sel_n     <= '1;
      tx_hold   <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        sel_n <= ~bus_wdata[EN_LSB +: NUM_SEL];
        if (!busy) div_code <= bus_wdata[DIV_W-1:0];
      end
      if (start_tx) tx_hold <= bus_wdata;
      bus_rdata <= rd_mux;
    end
  end

  AST_DIV_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(div_code));  // R8
  AST_TXHOLD_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(tx_hold));  // R8
  AST_SEL_ONLY_ON_CTRL: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(sel_n));  // R7

endmodule

// File: rtl/hdsm_top.sv
module hdsm_top #(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 2,
  parameter int NUM_SEL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe,
  input  logic              sdata_i,
  output logic [NUM_SEL-1:0] sel_n
);

  logic              busy;
  logic              start_tx;
  logic              start_rx;
  logic              rise_stb;
  logic              fall_stb;
  logic [DIV_W-1:0]  div_code;
  logic [DATA_W-1:0] rx_byte;

  hdsm_regs #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W),
    .NUM_SEL(NUM_SEL)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy     (busy),
    .rx_byte  (rx_byte),
    .div_code (div_code),
    .sel_n    (sel_n),
    .start_tx (start_tx),
    .start_rx (start_rx)
  );

  hdsm_clkgen #(
    .DIV_W(DIV_W)
  ) u_clkgen (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .div_code(div_code),
    .sclk    (sclk_o),
    .rise_stb(rise_stb),
    .fall_stb(fall_stb)
  );

  hdsm_engine #(
    .DATA_W(DATA_W)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .start_tx (start_tx),
    .start_rx (start_rx),
    .load_byte(bus_wdata),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .sdata_i  (sdata_i),
    .busy     (busy),
    .sdata_o  (sdata_o),
    .sdata_oe (sdata_oe),
    .rx_byte  (rx_byte)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sclk_o && !sdata_oe));  // R6
  AST_END_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && !fall_stb) |=> busy);  // R5

endmodule

// File: tb/tb_hdsm_top.sv
module tb_hdsm_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sclk_o, sdata_o, sdata_oe;
  logic       sdata_i = 1'b0;
  logic [1:0] sel_n;

  int checks = 0;
  int errors = 0;

  // vector: {is_tx, enable[1:0], div code[1:0], data[7:0]}
  localparam logic [12:0] VECS [0:7] = '{
    {1'b1, 2'b01, 2'd0, 8'hA5},
    {1'b1, 2'b10, 2'd1, 8'h3C},
    {1'b1, 2'b11, 2'd2, 8'hFF},
    {1'b1, 2'b00, 2'd3, 8'h00},
    {1'b0, 2'b01, 2'd0, 8'h5A},
    {1'b0, 2'b10, 2'd1, 8'h81},
    {1'b0, 2'b00, 2'd2, 8'hC3},
    {1'b0, 2'b11, 2'd3, 8'h7E}
  };

  hdsm_top dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o),
    .sdata_o(sdata_o), .sdata_oe(sdata_oe), .sdata_i(sdata_i), .sel_n(sel_n)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // Observe one transfer, starting at the negedge right after the start edge
  task automatic run_xfer(input bit is_tx, input logic [1:0] div,
                          input logic [7:0] data, input bit inject,
                          output logic [7:0] got, output int busy_cnt,
                          output int rises, output bit gap_ok, output bit oe_ok,
                          output logic [1:0] sel_mid, output logic [7:0] ctrl_rd,
                          output logic [7:0] tx_rd);
    int n = 2 << div;
    int last = 0;
    int hi = 0;
    bit prev = 1'b0;
    got = 8'h00; busy_cnt = 0; rises = 0; gap_ok = 1'b1; oe_ok = 1'b1;
    sel_mid = 2'b00; ctrl_rd = 8'h00; tx_rd = 8'h00;
    for (int c = 0; c < 8 * n + 4; c++) begin
      if (c > 0) @(negedge clk);
      if (inject) begin
        if (c == 3) begin bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h3C; end
        if (c == 4) begin bus_addr = 2'd0; bus_wdata = 8'h1C; end
        if (c == 5) bus_wr = 1'b0;
        if (c == 6) begin ctrl_rd = bus_rdata; bus_addr = 2'd2; end
        if (c == 7) begin tx_rd = bus_rdata; bus_addr = 2'd1; end
        busy_cnt += int'(sdata_oe);
      end else if (c > 0) begin
        busy_cnt += int'(bus_rdata[0]);
      end
      if (c == (inject ? 7 : 1)) sel_mid = sel_n;
      if (sclk_o) hi++;
      if (sclk_o && !prev) begin
        if (rises == 0 && c != n / 2) gap_ok = 1'b0;
        if (rises > 0 && (c - last) != n) gap_ok = 1'b0;
        last = c;
        if (is_tx) got = {got[6:0], sdata_o};
        if (is_tx && !sdata_oe) oe_ok = 1'b0;
        rises++;
      end
      if (!is_tx && sdata_oe) oe_ok = 1'b0;
      if (!sclk_o && !is_tx) sdata_i = (rises < 8) ? data[7 - rises] : 1'b0;
      prev = sclk_o;
    end
    if (hi != 4 * n) gap_ok = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    logic [7:0] rd, got, ctrl_rd, tx_rd;
    logic [1:0] sel_mid;
    int busy_cnt, rises;
    bit gap_ok, oe_ok;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sclk_o == 1'b0 && sdata_oe == 1'b0 && sdata_o == 1'b0, "R1 idle pins",
          {29'd0, sclk_o, sdata_oe, sdata_o}, 32'd0);
    check(sel_n == 2'b11, "R1 sel_n", sel_n, 2'b11);
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), rd);
      check(rd == 8'h00, "R1 R9 reset register read", rd, 8'h00);
    end

    // Table of transfers
    foreach (VECS[i]) begin
      logic       is_tx = VECS[i][12];
      logic [1:0] en    = VECS[i][11:10];
      logic [1:0] div   = VECS[i][9:8];
      logic [7:0] data  = VECS[i][7:0];
      int n = 2 << div;
      sdata_i = data[7];
      if (is_tx) begin
        bus_write(2'd0, {3'b000, 1'b0, en, div});
        bus_write(2'd2, data);
      end else begin
        bus_write(2'd0, {3'b000, 1'b1, en, div});
      end
      bus_addr = 2'd1;
      run_xfer(is_tx, div, data, 1'b0, got, busy_cnt, rises, gap_ok, oe_ok,
               sel_mid, ctrl_rd, tx_rd);
      check(busy_cnt == 8 * n, "R5 busy length", busy_cnt, 8 * n);
      check(rises == 8 && gap_ok, "R2 clock period and duty", rises, 8);
      check(sel_mid == ~en, "R7 enables held during transfer", sel_mid, ~en);
      check(sclk_o == 1'b0 && sdata_oe == 1'b0, "R6 idle after transfer",
            {sclk_o, sdata_oe}, 2'b00);
      if (is_tx) begin
        check(got == data, "R3 transmitted byte", got, data);
        check(oe_ok, "R3 line driven during transmit", oe_ok, 1);
      end else begin
        check(oe_ok, "R4 line released during receive", oe_ok, 1);
        bus_read(2'd3, rd);
        check(rd == data, "R4 received byte", rd, data);
      end
    end

    // Writes while busy: data, start bit and divider ignored, enables follow
    bus_write(2'd0, 8'h03);
    bus_write(2'd2, 8'hA5);
    bus_addr = 2'd1;
    run_xfer(1'b1, 2'd3, 8'hA5, 1'b1, got, busy_cnt, rises, gap_ok, oe_ok,
             sel_mid, ctrl_rd, tx_rd);
    check(ctrl_rd == 8'h0F, "R8 R9 divider kept, start bit reads 0", ctrl_rd, 8'h0F);
    check(tx_rd == 8'hA5, "R8 transmit register kept", tx_rd, 8'hA5);
    check(got == 8'hA5, "R8 shifted byte unchanged", got, 8'hA5);
    check(busy_cnt == 128 && rises == 8 && gap_ok, "R8 length unchanged", busy_cnt, 128);
    check(sel_mid == 2'b00, "R7 enables update while busy", sel_mid, 2'b00);
    bus_read(2'd1, rd);
    check(rd == 8'h00, "R8 no receive started", rd, 8'h00);
    check(sel_n == 2'b00, "R7 enables persist after transfer", sel_n, 2'b00);

    // Write on the very edge of the final falling edge is ignored
    bus_write(2'd0, 8'h00);
    bus_write(2'd2, 8'h96);
    repeat (14) @(negedge clk);
    bus_write(2'd2, 8'h5A);
    repeat (3) @(negedge clk);
    check(sclk_o == 1'b0 && sdata_oe == 1'b0, "R8 R6 end-edge write started nothing",
          {sclk_o, sdata_oe}, 2'b00);
    bus_read(2'd2, rd);
    check(rd == 8'h96, "R8 end-edge write not stored", rd, 8'h96);
    bus_read(2'd1, rd);
    check(rd == 8'h00, "R5 busy clear after end", rd, 8'h00);
    check(sel_n == 2'b11, "R7 enables released", sel_n, 2'b11);

    // A write right after the end is accepted
    bus_write(2'd2, 8'h5A);
    @(negedge clk);
    check(sdata_oe == 1'b1, "R3 start after idle", sdata_oe, 1);
    bus_read(2'd1, rd);
    check(rd == 8'h01, "R5 R9 status busy", rd, 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

endmodule